// File: doc/BRIEF.md
# SIMD Unsigned Less-or-Equal Compare Unit

This unit executes one vector instruction: an unsigned "less than or equal" test applied lane by lane across two 128-bit source operands. A two-bit format field in the instruction word sets the lane width to 8, 16, 32 or 64 bits. Each lane of the result becomes a mask: all ones when the first operand's lane is at most the second operand's lane, and all zeros otherwise. Both operands are treated as unsigned, zero-extended values, so no data value can raise a fault.

A pipeline front end presents the instruction word, the two operand values, a vector-unit enable and an input strobe. One clock later the unit returns the lane mask and the decoded register indices with a valid pulse. If the instruction fails the opcode checks, a reserved-encoding flag pulses instead. If the vector unit is switched off, a disabled flag pulses instead. In either case the previous result is kept.

Top module: `vcmp_ule_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, exc_reserved and exc_disabled are 0 and out_mask and all index outputs are 0.
- R2: With format 00 (byte), lane i covers bits 8i+7..8i for i = 0..15. That lane of out_mask is 8'hFF if src_a's lane is at most src_b's lane as an unsigned value, and 8'h00 otherwise.
- R3: With format 01 (halfword), the same rule applies to 8 lanes of 16 bits, with lane i at bits 16i+15..16i.
- R4: With format 10 (word), the same rule applies to 4 lanes of 32 bits, with lane i at bits 32i+31..32i.
- R5: With format 11 (doubleword), the same rule applies to 2 lanes of 64 bits, with lane i at bits 64i+63..64i.
- R6: Equal lanes produce an all-ones mask. A lane whose top bit is set compares as larger than any lane whose top bit is clear, because the test is unsigned.
- R7: A strobed instruction is reserved if bits 31..26 differ from 011110, or bits 25..23 differ from 101, or bits 5..0 differ from 001111. For a reserved instruction the next cycle has exc_reserved=1 and out_valid=0, and out_mask and the index outputs keep their previous values.
- R8: When an instruction is reserved and unit_en is 0, only exc_reserved is raised; exc_disabled stays 0.
- R9: A legal strobed instruction with unit_en=0 gives exc_disabled=1 and out_valid=0 on the next cycle, and out_mask and the index outputs are unchanged.
- R10: Results and flags appear exactly one clock after the in_valid strobe. In a cycle that follows one without a strobe, out_valid, exc_reserved and exc_disabled are all 0 and out_mask is held.
- R11: With a valid result, out_dst_idx, out_srca_idx and out_srcb_idx carry instruction bits 10..6, 15..11 and 20..16 respectively.
- R12: At most one of out_valid, exc_reserved and exc_disabled is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: instruction and operands are present |
| insn | input | 32 | Instruction word |
| src_a | input | 128 | First operand (left side of the test) |
| src_b | input | 128 | Second operand (right side of the test) |
| unit_en | input | 1 | Vector unit enable |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | 128 | Lane mask result |
| out_dst_idx | output | 5 | Destination register index |
| out_srca_idx | output | 5 | First operand register index |
| out_srcb_idx | output | 5 | Second operand register index |
| exc_reserved | output | 1 | Reserved-encoding exception pulse |
| exc_disabled | output | 1 | Vector-unit-disabled exception pulse |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector and a 32-bit instruction word. At these values all four lane widths can be reached, from sixteen byte lanes down to two doubleword lanes, along with the lane edges where a wrong slice offset would show up. The test values include equal lanes, lanes with the top bit set, and all-zero against all-ones operands, so a signed compare or a strict "less than" test fails visibly. Each fixed opcode field is corrupted on its own, and one case combines a bad encoding with the unit disabled, to check which exception wins and that the previous result is held.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  localparam int ILEN = 32;
  localparam int IDXW = 5;

  localparam logic [5:0] MAJOR_CODE = 6'b011110;
  localparam logic [2:0] OPSEL_CODE = 3'b101;
  localparam logic [5:0] MINOR_CODE = 6'b001111;

  typedef enum logic [1:0] {
    FMT_BYTE  = 2'b00,
    FMT_HALF  = 2'b01,
    FMT_WORD  = 2'b10,
    FMT_DWORD = 2'b11
  } lane_fmt_e;

  // bit layout of the instruction word, most significant field first
  typedef struct packed {
    logic [5:0]      major;
    logic [2:0]      opsel;
    lane_fmt_e       fmt;
    logic [IDXW-1:0] srcb;
    logic [IDXW-1:0] srca;
    logic [IDXW-1:0] dst;
    logic [5:0]      minor;
  } insn_fields_t;

  // unsigned less-or-equal on zero-extended lane values
  function automatic logic lane_ule(input logic [63:0] a, input logic [63:0] b);
    return a <= b;
  endfunction

  // lane width in bits for a format code
  function automatic int fmt_bits(input lane_fmt_e f);
    return 8 << f;
  endfunction

endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
  import vcmp_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output lane_fmt_e       fmt,
  output logic [IDXW-1:0] dst_idx,
  output logic [IDXW-1:0] srca_idx,
  output logic [IDXW-1:0] srcb_idx,
  output logic            legal
);

  insn_fields_t f;
  logic major_ok, opsel_ok, minor_ok;

  assign f        = insn_fields_t'(insn);
  assign major_ok = (f.major == MAJOR_CODE);
  assign opsel_ok = (f.opsel == OPSEL_CODE);
  assign minor_ok = (f.minor == MINOR_CODE);
  assign legal    = major_ok & opsel_ok & minor_ok;

  assign fmt      = f.fmt;
  assign dst_idx  = f.dst;
  assign srca_idx = f.srca;
  assign srcb_idx = f.srcb;

endmodule

// File: rtl/vcmp_lane_bank.sv
module vcmp_lane_bank #(
  parameter int VLEN = 128,
  parameter int LW   = 8
) (
  input  logic [VLEN-1:0] a,
  input  logic [VLEN-1:0] b,
  output logic [VLEN-1:0] mask
);

  localparam int NLANES = VLEN / LW;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic hit;
    assign hit = vcmp_pkg::lane_ule(64'(a[i*LW +: LW]), 64'(b[i*LW +: LW]));
    assign mask[i*LW +: LW] = {LW{hit}};
  end

endmodule

// File: rtl/vcmp_fmt_select.sv
module vcmp_fmt_select
  import vcmp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  lane_fmt_e       fmt,
  input  logic [VLEN-1:0] m_byte,
  input  logic [VLEN-1:0] m_half,
  input  logic [VLEN-1:0] m_word,
  input  logic [VLEN-1:0] m_dword,
  output logic [VLEN-1:0] mask
);

  always_comb begin
    unique case (fmt)
      FMT_BYTE: mask = m_byte;
      FMT_HALF: mask = m_half;
      FMT_WORD: mask = m_word;
      default:  mask = m_dword;
    endcase
  end

endmodule

// File: rtl/vcmp_ule_unit.sv
module vcmp_ule_unit
  import vcmp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [VLEN-1:0]  src_a,
  input  logic [VLEN-1:0]  src_b,
  input  logic             unit_en,
  output logic             out_valid,
  output logic [VLEN-1:0]  out_mask,
  output logic [4:0]       out_dst_idx,
  output logic [4:0]       out_srca_idx,
  output logic [4:0]       out_srcb_idx,
  output logic             exc_reserved,
  output logic             exc_disabled
);

  localparam int NFMT = 4;

  lane_fmt_e       fmt;
  logic [IDXW-1:0] dst_idx, srca_idx, srcb_idx;
  logic            legal;

  // named events for the checker
  logic            fire;
  logic            raise_reserved;
  logic            raise_disabled;
  logic [VLEN-1:0] sel_mask;
  logic [VLEN-1:0] bank_mask [NFMT];

  vcmp_decode i_decode (
    .insn     (insn),
    .fmt      (fmt),
    .dst_idx  (dst_idx),
    .srca_idx (srca_idx),
    .srcb_idx (srcb_idx),
    .legal    (legal)
  );

  for (genvar k = 0; k < NFMT; k++) begin : g_bank
    vcmp_lane_bank #(.VLEN(VLEN), .LW(8 << k)) i_bank (
      .a    (src_a),
      .b    (src_b),
      .mask (bank_mask[k])
    );
  end

  vcmp_fmt_select #(.VLEN(VLEN)) i_select (
    .fmt     (fmt),
    .m_byte  (bank_mask[0]),
    .m_half  (bank_mask[1]),
    .m_word  (bank_mask[2]),
    .m_dword (bank_mask[3]),
    .mask    (sel_mask)
  );

  assign raise_reserved = in_valid & ~legal;
  assign raise_disabled = in_valid & legal & ~unit_en;
  assign fire           = in_valid & legal & unit_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      exc_reserved <= 1'b0;
      exc_disabled <= 1'b0;
      out_mask     <= '0;
      out_dst_idx  <= '0;
      out_srca_idx <= '0;
      out_srcb_idx <= '0;
    end else begin
      out_valid    <= fire;
      exc_reserved <= raise_reserved;
      exc_disabled <= raise_disabled;
      if (fire) begin
        out_mask     <= sel_mask;
        out_dst_idx  <= dst_idx;
        out_srca_idx <= srca_idx;
        out_srcb_idx <= srcb_idx;
      end
    end
  end

endmodule

// File: rtl/vcmp_ule_chk.sv
module vcmp_ule_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            unit_en,
  input logic            legal,
  input logic            out_valid,
  input logic [VLEN-1:0] out_mask,
  input logic            exc_reserved,
  input logic            exc_disabled
);

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, exc_reserved, exc_disabled}));

  // R10
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !exc_reserved && !exc_disabled);

  // R7
  bad_encoding_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !legal |=> exc_reserved && !out_valid);

  // R8
  reserved_wins_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !legal && !unit_en |=> !exc_disabled);

  // R9
  unit_off_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal && !unit_en |=> exc_disabled && !out_valid);

  // R2
  for (genvar i = 0; i < VLEN/8; i++) begin : g_byte
    byte_mask_whole_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_mask[i*8 +: 8] == 8'h00) || (out_mask[i*8 +: 8] == 8'hFF));
  end

endmodule

bind vcmp_ule_unit vcmp_ule_chk #(.VLEN(VLEN)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .unit_en      (unit_en),
  .legal        (legal),
  .out_valid    (out_valid),
  .out_mask     (out_mask),
  .exc_reserved (exc_reserved),
  .exc_disabled (exc_disabled)
);

// File: tb/test_vcmp_ule_unit.sv
module test_vcmp_ule_unit;

  localparam int VL = 128;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [31:0]   insn;
  logic [VL-1:0] src_a, src_b;
  logic          unit_en;
  logic          out_valid;
  logic [VL-1:0] out_mask;
  logic [4:0]    out_dst_idx, out_srca_idx, out_srcb_idx;
  logic          exc_reserved, exc_disabled;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vcmp_ule_unit i_vcmp_ule_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_a(src_a), .src_b(src_b), .unit_en(unit_en),
    .out_valid(out_valid), .out_mask(out_mask),
    .out_dst_idx(out_dst_idx), .out_srca_idx(out_srca_idx), .out_srcb_idx(out_srcb_idx),
    .exc_reserved(exc_reserved), .exc_disabled(exc_disabled)
  );

  localparam logic [1:0] V_FMT [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
  localparam logic [VL-1:0] V_A [NV] = '{
    128'h00ff_7f80_0102_fe01_1000_0000_ffff_8081,
    128'h8000_0001_ff00_00ff_7fff_8000_1234_5678,
    128'hffff_0000_8000_7fff_1234_1235_abcd_0001,
    128'h0000_ffff_0001_8001_7ffe_5555_aaaa_ffff,
    128'hffff_ffff_0000_0000_8000_0000_7fff_ffff,
    128'h1234_5678_1234_5679_0000_0001_dead_beef,
    128'hffff_ffff_ffff_ffff_0000_0000_0000_0000,
    128'h8000_0000_0000_0000_0123_4567_89ab_cdef
  };
  localparam logic [VL-1:0] V_B [NV] = '{
    128'h00fe_7f81_0102_ff00_0f00_0001_ffff_8180,
    128'h7fff_0001_00ff_ff00_8000_7fff_1234_5677,
    128'h0000_ffff_7fff_8000_1234_1234_abcd_0000,
    128'h0000_fffe_0002_8000_7fff_5555_5555_ffff,
    128'h0000_0000_ffff_ffff_7fff_ffff_8000_0000,
    128'h1234_5678_1234_5678_0000_0001_dead_bef0,
    128'h0000_0000_0000_0000_ffff_ffff_ffff_ffff,
    128'h7fff_ffff_ffff_ffff_0123_4567_89ab_cdef
  };

  // lane masks built by subtracting and reading the borrow
  function automatic logic [VL-1:0] ref_mask(input logic [1:0] f, input logic [VL-1:0] a,
                                             input logic [VL-1:0] b);
    int lw;
    logic [VL-1:0] r;
    logic [63:0] m, la, lb;
    logic [64:0] d;
    lw = 8 << f;
    r  = '0;
    m  = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
    for (int i = 0; i < VL/lw; i++) begin
      la = 64'(a >> (i*lw)) & m;
      lb = 64'(b >> (i*lw)) & m;
      d  = {1'b0, lb} - {1'b0, la};
      if (!d[64]) r = r | ({64'd0, m} << (i*lw));
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_insn(input logic [1:0] f, input logic [4:0] wt,
                                          input logic [4:0] ws, input logic [4:0] wd);
    return {6'b011110, 3'b101, f, wt, ws, wd, 6'b001111};
  endfunction

  task automatic chk(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic issue(input logic [31:0] w, input logic [VL-1:0] a, input logic [VL-1:0] b,
                       input logic en);
    insn = w; src_a = a; src_b = b; unit_en = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [VL-1:0] held;

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; insn = '0; src_a = '0; src_b = '0; unit_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", VL'(out_valid), '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", VL'({out_valid, exc_reserved, exc_disabled}), '0);
    chk("R1 mask after reset", out_mask, '0);
    chk("R1 idx after reset", VL'({out_dst_idx, out_srca_idx, out_srcb_idx}), '0);

    // table walk: R2 R3 R4 R5 R6 by format
    for (int v = 0; v < NV; v++) begin
      issue(mk_insn(V_FMT[v], 5'(v + 3), 5'(v + 11), 5'(31 - v)), V_A[v], V_B[v], 1'b1);
      chk("R10 valid after strobe", VL'(out_valid), VL'(1));
      case (V_FMT[v])
        2'b00:   chk("R2 byte lanes", out_mask, ref_mask(V_FMT[v], V_A[v], V_B[v]));
        2'b01:   chk("R3 half lanes", out_mask, ref_mask(V_FMT[v], V_A[v], V_B[v]));
        2'b10:   chk("R4 word lanes", out_mask, ref_mask(V_FMT[v], V_A[v], V_B[v]));
        default: chk("R5 dword lanes", out_mask, ref_mask(V_FMT[v], V_A[v], V_B[v]));
      endcase
      chk("R11 indices", VL'({out_dst_idx, out_srca_idx, out_srcb_idx}),
          VL'({5'(31 - v), 5'(v + 11), 5'(v + 3)}));
    end

    // R6 equal operands give all ones; top-bit set is larger
    issue(mk_insn(2'b11, 5'd1, 5'd2, 5'd3), {2{64'h8000_0000_0000_0000}},
          {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, 1'b1);
    chk("R6 equal and unsigned", out_mask, {{64{1'b1}}, 64'd0});
    issue(mk_insn(2'b00, 5'd1, 5'd2, 5'd4), '0, '1, 1'b1);
    chk("R6 zero vs ones", out_mask, '1);
    issue(mk_insn(2'b00, 5'd1, 5'd2, 5'd5), '1, '0, 1'b1);
    chk("R6 ones vs zero", out_mask, '0);
    held = out_mask;

    // R10 idle cycle
    @(negedge clk);
    chk("R10 idle flags", VL'({out_valid, exc_reserved, exc_disabled}), '0);
    chk("R10 idle mask held", out_mask, held);

    // R7 each fixed field corrupted
    issue(mk_insn(2'b00, 5'd9, 5'd9, 5'd9) ^ 32'h8000_0000, '0, '1, 1'b1);
    chk("R7 major field", VL'({out_valid, exc_reserved, exc_disabled}), VL'(3'b010));
    chk("R7 mask held", out_mask, held);
    chk("R7 idx held", VL'(out_dst_idx), VL'(5'd5));
    issue(mk_insn(2'b00, 5'd9, 5'd9, 5'd9) ^ 32'h0080_0000, '0, '1, 1'b1);
    chk("R7 opsel field", VL'({out_valid, exc_reserved, exc_disabled}), VL'(3'b010));
    issue(mk_insn(2'b00, 5'd9, 5'd9, 5'd9) ^ 32'h0000_0001, '0, '1, 1'b1);
    chk("R7 minor field", VL'({out_valid, exc_reserved, exc_disabled}), VL'(3'b010));
    chk("R7 mask still held", out_mask, held);

    // R8 priority
    issue(mk_insn(2'b01, 5'd9, 5'd9, 5'd9) ^ 32'h0400_0000, '0, '1, 1'b0);
    chk("R8 reserved over disabled", VL'({out_valid, exc_reserved, exc_disabled}), VL'(3'b010));

    // R9 unit off
    issue(mk_insn(2'b10, 5'd7, 5'd8, 5'd9), '0, '1, 1'b0);
    chk("R9 disabled flag", VL'({out_valid, exc_reserved, exc_disabled}), VL'(3'b001));
    chk("R9 mask held", out_mask, held);
    chk("R9 idx held", VL'(out_dst_idx), VL'(5'd5));

    @(negedge clk);
    chk("R12 all quiet", VL'({out_valid, exc_reserved, exc_disabled}), '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule